// File: doc/BRIEF.md
# Dual-Line Serial ADC Burst Capture

This block runs a serial ADC front end that returns data on two lines at once. It drives one serial clock and one active-low frame signal. It shifts a sample in from each data line on the same clock edges, and it packs the two samples into one word of an internal dual-port RAM. A 3-bit select output steps an external analog multiplexer by one position after every frame. A processor reads the stored words through a separate read address.

Software sets up the block by writing a mode word. The mode word holds the serial clock divider and the burst length. A one-cycle start pulse, usually from a waveform generator, starts a burst. The burst runs frames back to back until the write pointer reaches the burst length. A clear strobe stops any capture in progress and rewinds the pointer and the multiplexer select. The live write pointer is visible on a status output.

Top module: `dual_line_adc_capture`

## Requirements
- R1: After reset, frame_n is 1, sclk is 0, mux_sel is 0 and wptr is 0.
- R2: The divider field D is mode bits [7:0]. A frame holds frame_n low for exactly 32*(D+1) clock cycles. During that time sclk makes exactly 16 low-to-high transitions, and sclk is low at the start and at the end of the frame. sclk is never high while frame_n is high.
- R3: Both data lines are sampled on the clock edge where sclk goes high, most significant bit first. The stored word holds the sdi_a sample in bits [31:16] and the sdi_b sample in bits [15:0].
- R4: Each completed frame stores its word at the address equal to wptr before the frame, then increments wptr by exactly 1.
- R5: mux_sel advances by one at the end of every completed frame and wraps from 7 to 0.
- R6: The burst length L is mode bits [25:16]. A trig pulse while idle with wptr < L starts frames that run until wptr equals L, and then capture stops. A trig pulse while wptr >= L starts no frame and leaves wptr unchanged.
- R7: A clr pulse aborts any frame. On the next cycle wptr is 0, mux_sel is 0 and frame_n is 1, and no frame starts again without a new trig.
- R8: rd_data shows the RAM word at rd_addr one clock after rd_addr is applied.
- R9: A mode_wr pulse loads the divider and length fields from wr_data. With L = 0, a trig pulse starts no frame.
- R10: Between two frames of one burst, frame_n stays high for exactly D+1 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Load strobe for the mode word |
| wr_data | input | 32 | Mode word: divider in [7:0], burst length in [25:16] |
| clr | input | 1 | Clear strobe: abort the capture, rewind the pointer and the select |
| trig | input | 1 | Start-burst pulse |
| rd_addr | input | 10 | RAM read address |
| rd_data | output | 32 | RAM read data, one cycle after the address |
| wptr | output | 10 | Current write pointer |
| sclk | output | 1 | Serial clock to the ADC |
| frame_n | output | 1 | Active-low frame / chip select |
| sdi_a | input | 1 | Serial data, line A |
| sdi_b | input | 1 | Serial data, line B |
| mux_sel | output | 3 | Analog multiplexer channel select |

## Verification
The assertions check the following on every cycle: sclk stays low outside a frame, the write pointer and the multiplexer select only step by one or return to zero, a frame never starts without room below the burst length, and a clear takes effect on the next cycle. The bench scenarios show the rest. These are the exact frame and gap lengths for several divider settings, the bit order and packing of the two lines into stored words, where a burst stops, and how a burst resumes after the length is raised. They also cover the ignored start pulses when the buffer is full or the length is zero, and an abort in the middle of a burst.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
   // bit position where the burst-length field starts in the mode word
   localparam int LEN_LSB = 16;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_GAP   = 2'd2
   } cap_state_t;
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] half_div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;

   assign tick = en && (cnt_q == half_div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (!en || tick)   cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/adc_lane_shift.sv
module adc_lane_shift #(
   parameter int SMP_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic             sdi,
   output logic [SMP_W-1:0] sample
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sample <= '0;
      else if (shift_en) sample <= {sample[SMP_W-2:0], sdi};
   end
endmodule

// File: rtl/adc_word_ram.sv
module adc_word_ram #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/dual_line_adc_capture.sv
module dual_line_adc_capture
   import adc_cap_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int SMP_W  = 16,
   parameter int DIV_W  = 8,
   parameter int BUS_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mode_wr,
   input  logic [BUS_W-1:0]   wr_data,
   input  logic               clr,
   input  logic               trig,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [2*SMP_W-1:0] rd_data,
   output logic [ADDR_W-1:0]  wptr,
   output logic               sclk,
   output logic               frame_n,
   input  logic               sdi_a,
   input  logic               sdi_b,
   output logic [2:0]         mux_sel
);
   localparam int NLANE   = 2;
   localparam int WORD_W  = NLANE * SMP_W;
   localparam int HC_W    = $clog2(2 * SMP_W);
   localparam logic [HC_W-1:0] HC_LAST = HC_W'(2 * SMP_W - 1);

   // elaboration-time parameter checks
   if (DIV_W >= LEN_LSB) begin : g_bad_div
      $error("DIV_W must stay below the length field");
   end
   if (LEN_LSB + ADDR_W >= BUS_W) begin : g_bad_len
      $error("length field must fit inside the bus");
   end
   if (SMP_W < 2 || ADDR_W < 1) begin : g_bad_size
      $error("SMP_W must be at least 2 and ADDR_W at least 1");
   end

   cap_state_t        st_q;
   logic [HC_W-1:0]   hc_q;
   logic              sclk_q;
   logic [ADDR_W-1:0] wptr_q;
   logic [ADDR_W-1:0] len_q;
   logic [DIV_W-1:0]  div_q;
   logic [2:0]        mux_q;
   logic              tick;
   logic              room;
   logic              rise_tick;
   logic              last_tick;
   logic [WORD_W-1:0] word;
   logic [NLANE-1:0]  sdi_vec;
   logic              unused_mode_bits;

   assign unused_mode_bits = ^{wr_data[BUS_W-1:LEN_LSB+ADDR_W], wr_data[LEN_LSB-1:DIV_W]};

   assign room      = wptr_q < len_q;
   assign rise_tick = tick && (st_q == ST_SHIFT) && !sclk_q;
   assign last_tick = tick && (st_q == ST_SHIFT) && (hc_q == HC_LAST);

   adc_clk_div #(.DIV_W(DIV_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (st_q != ST_IDLE),
      .half_div (div_q),
      .tick     (tick)
   );

   // lane 1 is line A (upper half of the word), lane 0 is line B
   assign sdi_vec = {sdi_a, sdi_b};

   for (genvar g = 0; g < NLANE; g++) begin : g_lane
      logic [SMP_W-1:0] smp;
      adc_lane_shift #(.SMP_W(SMP_W)) u_shift (
         .clk      (clk),
         .rst_n    (rst_n),
         .shift_en (rise_tick),
         .sdi      (sdi_vec[g]),
         .sample   (smp)
      );
      assign word[g*SMP_W +: SMP_W] = smp;
   end

   adc_word_ram #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) u_ram (
      .clk   (clk),
      .we    (last_tick && !clr),
      .waddr (wptr_q),
      .wdata (word),
      .raddr (rd_addr),
      .rdata (rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         hc_q   <= '0;
         sclk_q <= 1'b0;
         wptr_q <= '0;
         len_q  <= '0;
         div_q  <= '0;
         mux_q  <= '0;
      end else begin
         if (mode_wr) begin
            div_q <= wr_data[DIV_W-1:0];
            len_q <= wr_data[LEN_LSB +: ADDR_W];
         end
         if (clr) begin
            st_q   <= ST_IDLE;
            hc_q   <= '0;
            sclk_q <= 1'b0;
            wptr_q <= '0;
            mux_q  <= '0;
         end else begin
            unique case (st_q)
               ST_IDLE: begin
                  if (trig && room) begin
                     st_q   <= ST_SHIFT;
                     hc_q   <= '0;
                     sclk_q <= 1'b0;
                  end
               end
               ST_SHIFT: begin
                  if (tick) begin
                     sclk_q <= !sclk_q;
                     hc_q   <= hc_q + 1'b1;
                     if (hc_q == HC_LAST) begin
                        st_q   <= ST_GAP;
                        wptr_q <= wptr_q + 1'b1;
                        mux_q  <= mux_q + 3'd1;
                     end
                  end
               end
               ST_GAP: begin
                  if (tick) begin
                     hc_q <= '0;
                     st_q <= room ? ST_SHIFT : ST_IDLE;
                  end
               end
               default: st_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign sclk    = sclk_q;
   assign frame_n = (st_q != ST_SHIFT);
   assign wptr    = wptr_q;
   assign mux_sel = mux_q;

   // R2: serial clock only toggles inside a frame
   a_r2_sclk_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> !frame_n);

   // R4: pointer moves by one or returns to zero
   a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (wptr != $past(wptr)) |-> ((wptr == $past(wptr) + 1'b1) || (wptr == '0)));

   // R5: select steps by one with natural wrap, or is rewound
   a_r5_mux_step: assert property (@(posedge clk) disable iff (!rst_n)
      (mux_sel != $past(mux_sel)) |-> ((mux_sel == $past(mux_sel) + 3'd1) || (mux_sel == 3'd0)));

   // R6: a frame only opens while there is room below the burst length
   a_r6_start_room: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(frame_n) && !$past(mode_wr)) |-> (wptr < len_q));

   // R7: clear takes effect on the next cycle
   a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> ((wptr == '0) && frame_n && (mux_sel == 3'd0)));
endmodule

// File: tb/dual_line_adc_capture_tb_top.sv
module dual_line_adc_capture_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 4;
   localparam int        T_DIV [NVEC] = '{0, 1, 3, 2};
   localparam int        T_LEN [NVEC] = '{3, 10, 2, 9};
   localparam logic [15:0] T_SA [NVEC] = '{16'h1234, 16'hBEEF, 16'h0001, 16'hFFFF};
   localparam logic [15:0] T_SB [NVEC] = '{16'h8000, 16'h5A5A, 16'hC3C3, 16'h0000};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_wr = 1'b0;
   logic [31:0] wr_data = '0;
   logic        clr = 1'b0;
   logic        trig = 1'b0;
   logic [9:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [9:0]  wptr;
   logic        sclk;
   logic        frame_n;
   logic        sdi_a = 1'b0;
   logic        sdi_b = 1'b0;
   logic [2:0]  mux_sel;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_line_adc_capture dut_i (
      .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .wr_data(wr_data),
      .clr(clr), .trig(trig), .rd_addr(rd_addr), .rd_data(rd_data),
      .wptr(wptr), .sclk(sclk), .frame_n(frame_n),
      .sdi_a(sdi_a), .sdi_b(sdi_b), .mux_sel(mux_sel)
   );

   int n_chk = 0;
   int n_bad = 0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // ADC model: each frame k returns a known word per line
   logic [15:0] seed_a = '0, seed_b = '0;
   logic [15:0] cur_a = '0, cur_b = '0;
   int fcount = 0;
   int bitidx = 0;

   function automatic logic [15:0] pat_a(input int k);
      return 16'(seed_a + 16'(k) * 16'h1357 + 16'hA5C3);
   endfunction
   function automatic logic [15:0] pat_b(input int k);
      return 16'(seed_b ^ (16'(k) * 16'h0F0F) ^ 16'h3C00);
   endfunction

   always @(negedge frame_n) begin
      cur_a  = pat_a(fcount);
      cur_b  = pat_b(fcount);
      bitidx = 15;
      sdi_a  = cur_a[15];
      sdi_b  = cur_b[15];
   end
   always @(negedge sclk) begin
      if (bitidx > 0) begin
         bitidx = bitidx - 1;
         sdi_a  = cur_a[bitidx];
         sdi_b  = cur_b[bitidx];
      end
   end
   always @(posedge frame_n) fcount = fcount + 1;

   // timing monitor, sampled away from the active edge
   int lowcnt = 0, highcnt = 0, rises = 0;
   int last_low = 0, last_gap = 0, last_rises = 0, nfalls = 0;
   logic prev_fn = 1'b1, prev_sclk = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (!frame_n) begin
            lowcnt++;
            if (sclk && !prev_sclk) rises++;
            if (prev_fn) begin
               last_gap = highcnt;
               highcnt  = 0;
               nfalls++;
            end
         end else begin
            if (!prev_fn) begin
               last_low   = lowcnt;
               last_rises = rises;
               lowcnt     = 0;
               rises      = 0;
            end
            highcnt++;
         end
         prev_fn   = frame_n;
         prev_sclk = sclk;
      end
   end

   task automatic pulse_clear();
      @(negedge clk) clr = 1'b1;
      @(negedge clk) clr = 1'b0;
      fcount = 0;
   endtask

   task automatic write_mode(input int div, input int len);
      @(negedge clk);
      wr_data = {6'd0, 10'(len), 8'd0, 8'(div)};
      mode_wr = 1'b1;
      @(negedge clk) mode_wr = 1'b0;
   endtask

   task automatic pulse_trig();
      @(negedge clk) trig = 1'b1;
      @(negedge clk) trig = 1'b0;
   endtask

   task automatic wait_done(input int len, input int div);
      int guard = 0;
      while (!(wptr == 10'(len) && frame_n) && guard < 40000) begin
         @(negedge clk);
         guard++;
      end
      repeat (div + 4) @(negedge clk);
   endtask

   task automatic read_word(input int a, output logic [31:0] v);
      @(negedge clk) rd_addr = 10'(a);
      @(negedge clk) v = rd_data;
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL R6 watchdog act=hung exp=done");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      int f0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      fcount = 0;
      // R1 reset state
      check("R1 frame_n", 32'(frame_n), 32'd1);
      check("R1 sclk", 32'(sclk), 32'd0);
      check("R1 mux_sel", 32'(mux_sel), 32'd0);
      check("R1 wptr", 32'(wptr), 32'd0);

      // vector table walk
      for (int i = 0; i < NVEC; i++) begin
         pulse_clear();
         seed_a = T_SA[i];
         seed_b = T_SB[i];
         write_mode(T_DIV[i], T_LEN[i]);
         pulse_trig();
         wait_done(T_LEN[i], T_DIV[i]);
         check("R4 R6 wptr at burst end", 32'(wptr), 32'(T_LEN[i]));
         check("R5 mux_sel after burst", 32'(mux_sel), 32'(T_LEN[i] % 8));
         check("R2 frame low cycles", 32'(last_low), 32'(32 * (T_DIV[i] + 1)));
         check("R2 sclk rises per frame", 32'(last_rises), 32'd16);
         if (T_LEN[i] >= 2)
            check("R10 gap cycles", 32'(last_gap), 32'(T_DIV[i] + 1));
         for (int k = 0; k < T_LEN[i]; k++) begin
            read_word(k, v);
            check("R3 R8 stored word", v, {pat_a(k), pat_b(k)});
         end
      end

      // R6: full buffer ignores a trigger
      f0 = nfalls;
      pulse_trig();
      repeat (50) @(negedge clk);
      check("R6 no frame when full", 32'(nfalls), 32'(f0));
      check("R6 wptr unchanged when full", 32'(wptr), 32'd9);

      // R6 R9: raise the length, burst resumes from the pointer
      write_mode(2, 11);
      pulse_trig();
      wait_done(11, 2);
      check("R6 resumed wptr", 32'(wptr), 32'd11);
      check("R5 mux_sel wrap", 32'(mux_sel), 32'd3);
      read_word(9, v);
      check("R4 appended word 9", v, {pat_a(9), pat_b(9)});
      read_word(10, v);
      check("R4 appended word 10", v, {pat_a(10), pat_b(10)});
      read_word(8, v);
      check("R4 earlier word kept", v, {pat_a(8), pat_b(8)});

      // R7: abort in the middle of a burst
      pulse_clear();
      write_mode(1, 6);
      pulse_trig();
      repeat (100) @(negedge clk);
      check("R7 burst running before clear", 32'(frame_n), 32'd0);
      @(negedge clk) clr = 1'b1;
      @(negedge clk) clr = 1'b0;
      check("R7 wptr after clear", 32'(wptr), 32'd0);
      check("R7 frame_n after clear", 32'(frame_n), 32'd1);
      check("R7 mux_sel after clear", 32'(mux_sel), 32'd0);
      f0 = nfalls;
      repeat (40) @(negedge clk);
      check("R7 no restart without trig", 32'(nfalls), 32'(f0));

      // R9: zero length ignores a trigger
      write_mode(0, 0);
      pulse_clear();
      f0 = nfalls;
      pulse_trig();
      repeat (30) @(negedge clk);
      check("R9 zero length no frame", 32'(nfalls), 32'(f0));
      check("R9 zero length wptr", 32'(wptr), 32'd0);

      finish_run();
   end
endmodule